// File: doc/BRIEF.md
# Read-Protection Level Manager

The block turns a stored 8-bit protection option byte into one of three protection levels. From that level, and from the debug and boot status of the device, it decides whether an access to user flash or backup memory may go ahead. At the lowest level everything is open. At the middle level the memory is closed to a debugger and to code started from RAM or the system boot area, but stays open to code that booted from flash. The top level also shuts off the debug port and booting from the system area.

A second path handles requests to rewrite the option byte. A request that lowers the level from 1 to 0 first raises a mass-erase request and holds it until the erase engine acknowledges. Only then does the block issue a one-cycle commit strobe carrying the new byte to the option storage. A raise, or a request that keeps the level, commits at once with no erase. At level 2 every change is refused, so that level can never be left. A refused request produces a one-cycle protection-error pulse, and the stored byte is left as it was.

Top module: `rdp_level_mgr`

## Requirements
- R1: `prot_level` decodes `opt_byte` combinationally: 0xAA gives 0, 0xCC gives 2, and every other value gives 1.
- R2: At level 0, a read request is granted and a write request (program or erase) is granted when `sector_wr_ok` is 1, whatever the debug and boot status.
- R3: At level 1 or 2, while any of `dbg_attached`, `boot_ram` or `boot_sysmem` is 1, a read request is refused with `rd_bus_err` high in the same cycle, and a write request is refused.
- R4: At level 1 or 2 with none of the three status inputs set, a read request is granted and `rd_bus_err` stays low.
- R5: A write request is granted only when `sector_wr_ok` is 1. A write under the status of R3 is refused even when `sector_wr_ok` is 1.
- R6: `dbg_disable` and `sysboot_deny` are 1 exactly when the level is 2.
- R7: A request accepted at level 1 whose byte decodes to level 0 drives `erase_req` high from the next cycle until the cycle after `erase_done` is seen. In that next cycle `commit_stb` pulses with `commit_byte` equal to the requested byte. No commit occurs before the acknowledge.
- R8: A request accepted at level 0 or 1 whose byte does not decode to a lower level pulses `commit_stb` in the cycle after `chg_start`, carrying the requested byte, with `erase_req` staying low.
- R9: A request made at level 2 is refused. `prot_err` pulses in the next cycle, and no commit or erase follows.
- R10: A request made while `chg_busy` is 1 is refused with a `prot_err` pulse. The change already under way completes with its own byte.
- R11: After reset, `erase_req`, `commit_stb`, `prot_err` and `chg_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_byte | input | 8 | Stored protection option byte |
| chg_byte | input | 8 | Requested new option byte |
| chg_start | input | 1 | Start strobe for a change request |
| dbg_attached | input | 1 | Debugger connected |
| boot_ram | input | 1 | Device booted from RAM |
| boot_sysmem | input | 1 | Device booted from system memory |
| mem_rd_req | input | 1 | Read of user flash or backup memory requested |
| mem_wr_req | input | 1 | Program or erase of user memory requested |
| sector_wr_ok | input | 1 | Write-protect setting of the addressed sector allows writing |
| erase_done | input | 1 | Mass-erase acknowledge |
| prot_level | output | 2 | Decoded protection level (0, 1, 2) |
| mem_rd_grant | output | 1 | Read allowed |
| rd_bus_err | output | 1 | Read refused, bus error |
| mem_wr_grant | output | 1 | Program or erase allowed |
| dbg_disable | output | 1 | Debug port shut off |
| sysboot_deny | output | 1 | Boot from system memory forbidden |
| erase_req | output | 1 | Mass-erase request, held until acknowledged |
| commit_stb | output | 1 | One-cycle strobe writing `commit_byte` to option storage |
| commit_byte | output | 8 | Byte to be stored |
| prot_err | output | 1 | One-cycle pulse for a refused change request |
| chg_busy | output | 1 | A change request is in progress |

## Verification
The access permits are pure decode of the stored byte and the status inputs, so a wrong decode shows up at the grant and error outputs in the same cycle as the input pattern that exposes it. The change sequencer holds the only state. A wrong state or a wrongly latched level shows up one cycle after the strobe: as a missing or spurious erase request, as a commit that arrives before the acknowledge, or as a commit where a protection-error pulse was due. A wrongly latched byte shows up on `commit_byte`, and after the storage takes the commit it shows up again on the next cycle's level. The bench models the option storage, so each committed byte feeds back into the decode path.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef enum logic [1:0] {
    LVL0 = 2'd0,
    LVL1 = 2'd1,
    LVL2 = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_ERASE  = 2'd1,
    CH_COMMIT = 2'd2
  } chg_state_e;
endpackage

// File: rtl/rdp_rst_sync.sv
module rdp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rdp_decode.sv
module rdp_decode
  import rdp_pkg::*;
#(
  parameter int              OPT_W    = 8,
  parameter logic [OPT_W-1:0] KEY_OPEN = 8'hAA,
  parameter logic [OPT_W-1:0] KEY_LOCK = 8'hCC
) (
  input  logic [OPT_W-1:0] byte_in,
  output lvl_e             lvl
);
  always_comb begin
    if (byte_in == KEY_OPEN)      lvl = LVL0;
    else if (byte_in == KEY_LOCK) lvl = LVL2;
    else                          lvl = LVL1;
  end
endmodule

// File: rtl/rdp_gate.sv
module rdp_gate
  import rdp_pkg::*;
(
  input  logic clk,
  input  logic rst_sync_n,
  input  lvl_e lvl,
  input  logic dbg_attached,
  input  logic boot_ram,
  input  logic boot_sysmem,
  input  logic rd_req,
  input  logic wr_req,
  input  logic sector_wr_ok,
  output logic rd_grant,
  output logic rd_err,
  output logic wr_grant,
  output logic dbg_off,
  output logic sysboot_off
);
  logic untrusted;
  logic closed;

  always_comb begin
    untrusted   = dbg_attached | boot_ram | boot_sysmem;
    closed      = (lvl != LVL0) & untrusted;
    rd_grant    = rd_req & ~closed;
    rd_err      = rd_req & closed;
    wr_grant    = wr_req & sector_wr_ok & ~closed;
    dbg_off     = (lvl == LVL2);
    sysboot_off = (lvl == LVL2);
  end

  AST_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(rd_grant && rd_err)); // R3
  AST_DEBUG_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lvl != LVL0 && dbg_attached) |-> !wr_grant); // R5
  AST_OPEN_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lvl == LVL0 && rd_req) |-> rd_grant); // R2
endmodule

// File: rtl/rdp_change_seq.sv
module rdp_change_seq
  import rdp_pkg::*;
#(
  parameter int OPT_W = 8
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  lvl_e             cur_lvl,
  input  lvl_e             req_lvl,
  input  logic [OPT_W-1:0] req_byte,
  input  logic             start,
  input  logic             erase_done,
  output logic             erase_req,
  output logic             commit_stb,
  output logic [OPT_W-1:0] commit_byte,
  output logic             prot_err,
  output logic             busy
);
  chg_state_e       state_q, state_d;
  logic [OPT_W-1:0] pend_q;
  lvl_e             orig_q, pend_lvl_q;
  logic             err_q, err_d;
  logic             cap_en;

  always_comb begin
    state_d = state_q;
    err_d   = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      CH_IDLE: begin
        if (start) begin
          if (cur_lvl == LVL2) begin
            err_d = 1'b1;
          end else begin
            cap_en = 1'b1;
            if (cur_lvl == LVL1 && req_lvl == LVL0) state_d = CH_ERASE;
            else                                    state_d = CH_COMMIT;
          end
        end
      end
      CH_ERASE: begin
        err_d = start;
        if (erase_done) state_d = CH_COMMIT;
      end
      CH_COMMIT: begin
        err_d   = start;
        state_d = CH_IDLE;
      end
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q    <= CH_IDLE;
      err_q      <= 1'b0;
      pend_q     <= '0;
      orig_q     <= LVL1;
      pend_lvl_q <= LVL1;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (cap_en) begin
        pend_q     <= req_byte;
        orig_q     <= cur_lvl;
        pend_lvl_q <= req_lvl;
      end
    end
  end

  assign erase_req   = (state_q == CH_ERASE);
  assign commit_stb  = (state_q == CH_COMMIT);
  assign commit_byte = pend_q;
  assign prot_err    = err_q;
  assign busy        = (state_q != CH_IDLE);

  AST_DOWN_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (commit_stb && orig_q == LVL1 && pend_lvl_q == LVL0) |-> $past(erase_done)); // R7
  AST_ERASE_ONLY_DOWN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    erase_req |-> (orig_q == LVL1 && pend_lvl_q == LVL0)); // R8
  AST_TOP_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    commit_stb |-> orig_q != LVL2); // R9
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({erase_req, commit_stb})); // R7
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    commit_stb |=> !commit_stb); // R8
  AST_ERR_PULSE_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && start) |=> prot_err); // R10
endmodule

// File: rtl/rdp_level_mgr.sv
module rdp_level_mgr
  import rdp_pkg::*;
#(
  parameter int               OPT_W    = 8,
  parameter logic [OPT_W-1:0] KEY_OPEN = 8'hAA,
  parameter logic [OPT_W-1:0] KEY_LOCK = 8'hCC,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPT_W-1:0] opt_byte,
  input  logic [OPT_W-1:0] chg_byte,
  input  logic             chg_start,
  input  logic             dbg_attached,
  input  logic             boot_ram,
  input  logic             boot_sysmem,
  input  logic             mem_rd_req,
  input  logic             mem_wr_req,
  input  logic             sector_wr_ok,
  input  logic             erase_done,
  output logic [1:0]       prot_level,
  output logic             mem_rd_grant,
  output logic             rd_bus_err,
  output logic             mem_wr_grant,
  output logic             dbg_disable,
  output logic             sysboot_deny,
  output logic             erase_req,
  output logic             commit_stb,
  output logic [OPT_W-1:0] commit_byte,
  output logic             prot_err,
  output logic             chg_busy
);
  logic rst_sync_n;
  lvl_e cur_lvl;
  lvl_e req_lvl;

  rdp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  rdp_decode #(.OPT_W(OPT_W), .KEY_OPEN(KEY_OPEN), .KEY_LOCK(KEY_LOCK)) u_dec_cur (
    .byte_in(opt_byte), .lvl(cur_lvl)
  );

  rdp_decode #(.OPT_W(OPT_W), .KEY_OPEN(KEY_OPEN), .KEY_LOCK(KEY_LOCK)) u_dec_req (
    .byte_in(chg_byte), .lvl(req_lvl)
  );

  rdp_gate u_gate (
    .clk(clk), .rst_sync_n(rst_sync_n), .lvl(cur_lvl),
    .dbg_attached(dbg_attached), .boot_ram(boot_ram), .boot_sysmem(boot_sysmem),
    .rd_req(mem_rd_req), .wr_req(mem_wr_req), .sector_wr_ok(sector_wr_ok),
    .rd_grant(mem_rd_grant), .rd_err(rd_bus_err), .wr_grant(mem_wr_grant),
    .dbg_off(dbg_disable), .sysboot_off(sysboot_deny)
  );

  rdp_change_seq #(.OPT_W(OPT_W)) u_seq (
    .clk(clk), .rst_sync_n(rst_sync_n), .cur_lvl(cur_lvl), .req_lvl(req_lvl),
    .req_byte(chg_byte), .start(chg_start), .erase_done(erase_done),
    .erase_req(erase_req), .commit_stb(commit_stb), .commit_byte(commit_byte),
    .prot_err(prot_err), .busy(chg_busy)
  );

  assign prot_level = cur_lvl;

  AST_LOCK_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dbg_disable == (prot_level == 2'd2)); // R6
endmodule

// File: tb/rdp_level_mgr_test.sv
module rdp_level_mgr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] chg_byte = 8'h00;
  logic       chg_start = 1'b0, dbg_attached = 1'b0, boot_ram = 1'b0, boot_sysmem = 1'b0;
  logic       mem_rd_req = 1'b0, mem_wr_req = 1'b0, sector_wr_ok = 1'b0, erase_done = 1'b0;
  logic [7:0] stor;
  logic [7:0] ld_val = 8'h55;
  logic       ld_en = 1'b1;
  logic [1:0] prot_level;
  logic       mem_rd_grant, rd_bus_err, mem_wr_grant, dbg_disable, sysboot_deny;
  logic       erase_req, commit_stb, prot_err, chg_busy;
  logic [7:0] commit_byte;
  int         n_cmp = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    if (ld_en)           stor <= ld_val;
    else if (commit_stb) stor <= commit_byte;
  end

  rdp_level_mgr uut (
    .clk(clk), .rst_n(rst_n), .opt_byte(stor), .chg_byte(chg_byte), .chg_start(chg_start),
    .dbg_attached(dbg_attached), .boot_ram(boot_ram), .boot_sysmem(boot_sysmem),
    .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .sector_wr_ok(sector_wr_ok),
    .erase_done(erase_done), .prot_level(prot_level), .mem_rd_grant(mem_rd_grant),
    .rd_bus_err(rd_bus_err), .mem_wr_grant(mem_wr_grant), .dbg_disable(dbg_disable),
    .sysboot_deny(sysboot_deny), .erase_req(erase_req), .commit_stb(commit_stb),
    .commit_byte(commit_byte), .prot_err(prot_err), .chg_busy(chg_busy)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  task automatic set_byte(input logic [7:0] v);
    ld_val = v; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic start_req(input logic [7:0] v);
    chg_byte = v; chg_start = 1'b1;
    @(negedge clk);
    chg_start = 1'b0;
  endtask

  // fields: byte, dbg, ram, sys, rd, wr, wp, level, rd_grant, rd_err, wr_grant, lock
  localparam int NV = 12;
  localparam logic [19:0] TBL [NV] = '{
    {8'hAA, 6'b100111, 2'd0, 4'b1010},
    {8'hAA, 6'b000110, 2'd0, 4'b1000},
    {8'h55, 6'b100111, 2'd1, 4'b0100},
    {8'h55, 6'b010111, 2'd1, 4'b0100},
    {8'h55, 6'b001111, 2'd1, 4'b0100},
    {8'h55, 6'b000111, 2'd1, 4'b1010},
    {8'hFF, 6'b000100, 2'd1, 4'b1000},
    {8'hCC, 6'b000111, 2'd2, 4'b1011},
    {8'hCC, 6'b100111, 2'd2, 4'b0101},
    {8'h00, 6'b000000, 2'd1, 4'b0000},
    {8'hCD, 6'b001011, 2'd1, 4'b0000},
    {8'hAB, 6'b000100, 2'd1, 4'b1000}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ld_en = 1'b0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 erase_req", {7'd0, erase_req}, 8'd0);
    chk("R11 commit_stb", {7'd0, commit_stb}, 8'd0);
    chk("R11 prot_err", {7'd0, prot_err}, 8'd0);
    chk("R11 chg_busy", {7'd0, chg_busy}, 8'd0);

    // access table: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      set_byte(TBL[i][19:12]);
      {dbg_attached, boot_ram, boot_sysmem, mem_rd_req, mem_wr_req, sector_wr_ok} = TBL[i][11:6];
      #1;
      chk("R1 level", {6'd0, prot_level}, {6'd0, TBL[i][5:4]});
      chk("R2/R4 rd_grant", {7'd0, mem_rd_grant}, {7'd0, TBL[i][3]});
      chk("R3 rd_bus_err", {7'd0, rd_bus_err}, {7'd0, TBL[i][2]});
      chk("R5 wr_grant", {7'd0, mem_wr_grant}, {7'd0, TBL[i][1]});
      chk("R6 dbg_disable", {7'd0, dbg_disable}, {7'd0, TBL[i][0]});
      chk("R6 sysboot_deny", {7'd0, sysboot_deny}, {7'd0, TBL[i][0]});
      @(negedge clk);
    end
    {dbg_attached, boot_ram, boot_sysmem, mem_rd_req, mem_wr_req, sector_wr_ok} = 6'b0;

    // R7 downgrade with erase handshake, R10 busy refusal
    set_byte(8'h55);
    start_req(8'hAA);
    chk("R7 erase_req up", {7'd0, erase_req}, 8'd1);
    chk("R7 no early commit", {7'd0, commit_stb}, 8'd0);
    chg_byte = 8'hCC; chg_start = 1'b1;
    @(negedge clk);
    chg_start = 1'b0;
    chk("R10 prot_err busy", {7'd0, prot_err}, 8'd1);
    chk("R10 erase held", {7'd0, erase_req}, 8'd1);
    repeat (3) @(negedge clk);
    chk("R7 erase still held", {7'd0, erase_req}, 8'd1);
    chk("R7 storage unchanged", stor, 8'h55);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    chk("R7 commit after ack", {7'd0, commit_stb}, 8'd1);
    chk("R7 commit byte", commit_byte, 8'hAA);
    chk("R7 erase dropped", {7'd0, erase_req}, 8'd0);
    @(negedge clk);
    chk("R7 new level", {6'd0, prot_level}, 8'd0);
    chk("R7 commit pulse", {7'd0, commit_stb}, 8'd0);

    // R8 raise 0 -> 1
    start_req(8'h5A);
    chk("R8 commit 0to1", {7'd0, commit_stb}, 8'd1);
    chk("R8 no erase 0to1", {7'd0, erase_req}, 8'd0);
    chk("R8 byte 0to1", commit_byte, 8'h5A);
    @(negedge clk);
    chk("R8 level 1", {6'd0, prot_level}, 8'd1);

    // R8 same level 1 -> 1
    start_req(8'h77);
    chk("R8 commit 1to1", {7'd0, commit_stb}, 8'd1);
    chk("R8 no erase 1to1", {7'd0, erase_req}, 8'd0);
    @(negedge clk);
    chk("R8 stored 77", stor, 8'h77);

    // R8 raise 0 -> 2
    set_byte(8'hAA);
    start_req(8'hCC);
    chk("R8 commit 0to2", {7'd0, commit_stb}, 8'd1);
    chk("R8 no erase 0to2", {7'd0, erase_req}, 8'd0);
    @(negedge clk);
    chk("R8 level 2", {6'd0, prot_level}, 8'd2);

    // R9 level 2 refuses any change
    start_req(8'hAA);
    chk("R9 prot_err", {7'd0, prot_err}, 8'd1);
    chk("R9 no commit", {7'd0, commit_stb}, 8'd0);
    chk("R9 no erase", {7'd0, erase_req}, 8'd0);
    @(negedge clk);
    chk("R9 err pulse ends", {7'd0, prot_err}, 8'd0);
    chk("R9 byte kept", stor, 8'hCC);
    start_req(8'hCC);
    chk("R9 same-byte refused", {7'd0, prot_err}, 8'd1);
    @(negedge clk);
    chk("R9 still level 2", {6'd0, prot_level}, 8'd2);

    finish_run();
  end
endmodule